// File: doc/BRIEF.md
# Display PHY Test-Port Register Writer

This block programs the internal configuration registers of a display PHY through its narrow serial test port: a clear line, a test clock, an enable line and an 8-bit data bus. A requester hands over an 8-bit register code and an 8-bit value with a valid/ready handshake. The block then produces the four port phases in sequence. Each phase is held for a fixed number of system clocks, so the port timing holds at any system clock rate. The requester can also issue a clear command, which pulses the clear line before any programming starts.

Two helpers sit beside the sequencer. The first is a band lookup that maps a requested lane rate in Mbps to a frequency-range index. It uses an ordered table of band maxima that is computed from parameters. The second is a completion waiter. After the PHY leaves reset, the waiter watches for a lock flag and then for a clock-lane stop-state flag. Each of the two stages has its own timeout window, and a timeout is reported together with the stage that failed.

Top module: `phy_tport_writer`

## Requirements
- R1: After reset, and whenever the sequencer is idle, the test clock is high, the clear and enable lines are low, the data bus is 0x00 and req_ready_o is high.
- R2: A clear request (req_clear_i=1) holds the clear line low for HOLD_CYC cycles and then high for HOLD_CYC cycles, then returns it low. During the whole command the test clock stays high and enable stays low.
- R3: A write request begins with HOLD_CYC cycles in which the test clock is high, enable is high and the data bus carries the register code.
- R4: The test clock then falls while enable stays high and the code stays on the bus, and this level is held for HOLD_CYC cycles.
- R5: Enable then drops and the data byte replaces the code, with the clock still low, for HOLD_CYC cycles. The clock then rises and is held high for HOLD_CYC cycles with the data byte still on the bus.
- R6: req_done_o pulses for exactly one cycle, in the first idle cycle after a command ends. req_ready_o is low while a command is in progress, and a request presented during that time is ignored.
- R7: A request presented in the cycle that req_done_o is high is accepted at the next clock edge, with no idle gap.
- R8: Band i has a maximum rate of BAND_BASE + i*BAND_STEP Mbps, except the last band, whose maximum is BAND_TOP (1500 by default). band_sel_o is the lowest index whose maximum is greater than or equal to band_rate_i. The lookup is combinational.
- R9: band_err_o is high exactly when band_rate_i exceeds BAND_TOP.
- R10: A pulse on wait_start_i makes the waiter busy. It waits for lock_i and then for stop_i. When stop_i is seen, it pulses wait_done_o with wait_fail_o low.
- R11: Each stage allows TIMEOUT_CYC cycles. If the flag does not arrive in time, wait_done_o and wait_fail_o pulse together. wait_fail_stage_o then reads 0 for a lock timeout or 1 for a stop-state timeout, and holds that value until the next failure.
- R12: A flag that is present in the last cycle of a stage's window counts as arrival. It takes priority over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Command request valid |
| req_clear_i | input | 1 | 1 = clear command, 0 = register write |
| req_code_i | input | 8 | Register code |
| req_data_i | input | 8 | Register value |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| req_done_o | output | 1 | One-cycle completion pulse |
| testclr_o | output | 1 | Test-port clear line |
| testclk_o | output | 1 | Test-port clock |
| testen_o | output | 1 | Test-port enable (code phase) |
| testdin_o | output | 8 | Test-port data bus |
| band_rate_i | input | RATE_W | Requested lane rate in Mbps |
| band_sel_o | output | $clog2(NUM_BANDS) | Selected band index |
| band_err_o | output | 1 | Rate above the top band |
| wait_start_i | input | 1 | Start the lock/stop-state wait |
| lock_i | input | 1 | PHY lock flag |
| stop_i | input | 1 | Clock-lane stop-state flag |
| wait_busy_o | output | 1 | Waiter active |
| wait_done_o | output | 1 | Waiter finished (one cycle) |
| wait_fail_o | output | 1 | Waiter timed out (with done) |
| wait_fail_stage_o | output | 1 | Stage of last timeout: 0 lock, 1 stop |

## Verification
Two pairs of events can land in the same cycle. In the sequencer, a completion pulse can coincide with a new request. The bench raises req_valid_i as soon as it sees req_done_o, and it requires the next command's first phase to start on the following edge. In the waiter, a flag's arrival can coincide with the last cycle of its timeout window. The bench counts edges from the start pulse and raises lock_i exactly in the final window cycle. It then requires a move to the stop stage with no failure. A behavioural queue model predicts every port level on every cycle, and a mismatch in any phase is reported against the requirement that covers that phase.

// File: rtl/phy_tport_pkg.sv
package phy_tport_pkg;

  typedef enum logic [2:0] {
    WR_IDLE,
    WR_CLR_LO,
    WR_CLR_HI,
    WR_CODE_SET,
    WR_CODE_LATCH,
    WR_DATA_SET,
    WR_DATA_COMMIT
  } wr_state_e;

  typedef enum logic [1:0] {
    WT_IDLE,
    WT_LOCK,
    WT_STOP
  } wt_state_e;

endpackage

// File: rtl/phy_tport_seq.sv
module phy_tport_seq
  import phy_tport_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       clear_i,
  input  logic [7:0] code_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       done_o,
  output logic       testclr_o,
  output logic       testclk_o,
  output logic       testen_o,
  output logic [7:0] testdin_o
);

  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  wr_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    code_q, data_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      cnt_q   <= '0;
      code_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == WR_IDLE) begin
        cnt_q <= '0;
        if (valid_i) begin
          state_q <= clear_i ? WR_CLR_LO : WR_CODE_SET;
          code_q  <= code_i;
          data_q  <= data_i;
        end
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        unique case (state_q)
          WR_CLR_LO:      state_q <= WR_CLR_HI;
          WR_CODE_SET:    state_q <= WR_CODE_LATCH;
          WR_CODE_LATCH:  state_q <= WR_DATA_SET;
          WR_DATA_SET:    state_q <= WR_DATA_COMMIT;
          default: begin
            state_q <= WR_IDLE;
            done_q  <= 1'b1;
          end
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    testclr_o = (state_q == WR_CLR_HI);
    testclk_o = !((state_q == WR_CODE_LATCH) || (state_q == WR_DATA_SET));
    testen_o  = (state_q == WR_CODE_SET) || (state_q == WR_CODE_LATCH);
    if (testen_o)
      testdin_o = code_q;
    else if ((state_q == WR_DATA_SET) || (state_q == WR_DATA_COMMIT))
      testdin_o = data_q;
    else
      testdin_o = 8'h00;
  end

  assign ready_o = (state_q == WR_IDLE);
  assign done_o  = done_q;

endmodule

// File: rtl/phy_band_lookup.sv
module phy_band_lookup #(
  parameter int RATE_W    = 12,
  parameter int NUM_BANDS = 36,
  parameter int BAND_BASE = 89,
  parameter int BAND_STEP = 40,
  parameter int BAND_TOP  = 1500
) (
  input  logic [RATE_W-1:0]            rate_i,
  output logic [$clog2(NUM_BANDS)-1:0] sel_o,
  output logic                         err_o
);

  localparam int SW = $clog2(NUM_BANDS);

  logic [NUM_BANDS-1:0] hit;

  for (genvar i = 0; i < NUM_BANDS; i++) begin : g_band
    localparam int MAXV = (i == NUM_BANDS - 1) ? BAND_TOP : BAND_BASE + i * BAND_STEP;
    assign hit[i] = (int'(rate_i) <= MAXV);
  end

  always_comb begin
    sel_o = '0;
    for (int i = NUM_BANDS - 1; i >= 0; i--) begin
      if (hit[i]) sel_o = SW'(i);
    end
  end

  assign err_o = ~|hit;

endmodule

// File: rtl/phy_lock_waiter.sv
module phy_lock_waiter
  import phy_tport_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic lock_i,
  input  logic stop_i,
  output logic busy_o,
  output logic done_o,
  output logic fail_o,
  output logic fail_stage_o
);

  localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  wt_state_e     state_q;
  logic [TW-1:0] cnt_q;
  logic          done_q, fail_q, stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WT_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      stage_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      unique case (state_q)
        WT_IDLE: begin
          cnt_q <= '0;
          if (start_i) state_q <= WT_LOCK;
        end
        WT_LOCK: begin
          if (lock_i) begin
            state_q <= WT_STOP;
            cnt_q   <= '0;
          end else if (cnt_q == LAST) begin
            state_q <= WT_IDLE;
            done_q  <= 1'b1;
            fail_q  <= 1'b1;
            stage_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (stop_i) begin
            state_q <= WT_IDLE;
            done_q  <= 1'b1;
          end else if (cnt_q == LAST) begin
            state_q <= WT_IDLE;
            done_q  <= 1'b1;
            fail_q  <= 1'b1;
            stage_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o       = (state_q != WT_IDLE);
  assign done_o       = done_q;
  assign fail_o       = fail_q;
  assign fail_stage_o = stage_q;

endmodule

// File: rtl/phy_tport_writer.sv
module phy_tport_writer #(
  parameter int HOLD_CYC    = 4,
  parameter int TIMEOUT_CYC = 2000000,
  parameter int RATE_W      = 12,
  parameter int NUM_BANDS   = 36,
  parameter int BAND_BASE   = 89,
  parameter int BAND_STEP   = 40,
  parameter int BAND_TOP    = 1500
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  input  logic                         req_clear_i,
  input  logic [7:0]                   req_code_i,
  input  logic [7:0]                   req_data_i,
  output logic                         req_ready_o,
  output logic                         req_done_o,
  output logic                         testclr_o,
  output logic                         testclk_o,
  output logic                         testen_o,
  output logic [7:0]                   testdin_o,
  input  logic [RATE_W-1:0]            band_rate_i,
  output logic [$clog2(NUM_BANDS)-1:0] band_sel_o,
  output logic                         band_err_o,
  input  logic                         wait_start_i,
  input  logic                         lock_i,
  input  logic                         stop_i,
  output logic                         wait_busy_o,
  output logic                         wait_done_o,
  output logic                         wait_fail_o,
  output logic                         wait_fail_stage_o
);

  phy_tport_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (req_valid_i),
    .clear_i   (req_clear_i),
    .code_i    (req_code_i),
    .data_i    (req_data_i),
    .ready_o   (req_ready_o),
    .done_o    (req_done_o),
    .testclr_o (testclr_o),
    .testclk_o (testclk_o),
    .testen_o  (testen_o),
    .testdin_o (testdin_o)
  );

  phy_band_lookup #(
    .RATE_W   (RATE_W),
    .NUM_BANDS(NUM_BANDS),
    .BAND_BASE(BAND_BASE),
    .BAND_STEP(BAND_STEP),
    .BAND_TOP (BAND_TOP)
  ) u_band (
    .rate_i(band_rate_i),
    .sel_o (band_sel_o),
    .err_o (band_err_o)
  );

  phy_lock_waiter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wait (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (wait_start_i),
    .lock_i      (lock_i),
    .stop_i      (stop_i),
    .busy_o      (wait_busy_o),
    .done_o      (wait_done_o),
    .fail_o      (wait_fail_o),
    .fail_stage_o(wait_fail_stage_o)
  );

endmodule

// File: rtl/phy_tport_writer_chk.sv
module phy_tport_writer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic req_done_o,
  input logic testclr_o,
  input logic testclk_o,
  input logic testen_o,
  input logic wait_busy_o,
  input logic wait_done_o,
  input logic wait_fail_o
);

  AST_CLR_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    testclr_o |-> (testclk_o && !testen_o)); // R2

  AST_EN_RISE_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(testen_o) |-> testclk_o); // R3

  AST_FALL_WITH_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(testclk_o) |-> testen_o); // R4

  AST_RISE_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(testclk_o) |-> !testen_o); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |=> !req_done_o); // R6

  AST_DONE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |-> req_ready_o); // R6

  AST_WAIT_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_done_o |-> !wait_busy_o); // R10

  AST_FAIL_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_fail_o |-> wait_done_o); // R11

endmodule

bind phy_tport_writer phy_tport_writer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .req_done_o (req_done_o),
  .testclr_o  (testclr_o),
  .testclk_o  (testclk_o),
  .testen_o   (testen_o),
  .wait_busy_o(wait_busy_o),
  .wait_done_o(wait_done_o),
  .wait_fail_o(wait_fail_o)
);

// File: tb/phy_tport_writer_tb_top.sv
module phy_tport_writer_tb_top;

  localparam int H   = 3;
  localparam int TO  = 20;
  localparam int RW  = 12;
  localparam int NB  = 36;
  localparam int BB  = 89;
  localparam int BS  = 40;
  localparam int BT  = 1500;
  localparam int SW  = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 0, req_clear = 0;
  logic [7:0]    req_code = 0, req_data = 0;
  logic          req_ready, req_done;
  logic          tclr, tclk, ten;
  logic [7:0]    tdin;
  logic [RW-1:0] band_rate = 0;
  logic [SW-1:0] band_sel;
  logic          band_err;
  logic          wstart = 0, lock = 0, stop = 0;
  logic          wbusy, wdone, wfail, wstage;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  phy_tport_writer #(
    .HOLD_CYC(H), .TIMEOUT_CYC(TO), .RATE_W(RW),
    .NUM_BANDS(NB), .BAND_BASE(BB), .BAND_STEP(BS), .BAND_TOP(BT)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_clear_i(req_clear),
    .req_code_i(req_code), .req_data_i(req_data),
    .req_ready_o(req_ready), .req_done_o(req_done),
    .testclr_o(tclr), .testclk_o(tclk), .testen_o(ten), .testdin_o(tdin),
    .band_rate_i(band_rate), .band_sel_o(band_sel), .band_err_o(band_err),
    .wait_start_i(wstart), .lock_i(lock), .stop_i(stop),
    .wait_busy_o(wbusy), .wait_done_o(wdone), .wait_fail_o(wfail),
    .wait_fail_stage_o(wstage)
  );

  typedef struct packed {
    logic       clr;
    logic       ck;
    logic       en;
    logic [7:0] din;
    logic       done;
    logic       rdy;
  } exp_t;

  localparam exp_t IDLE_E = '{clr:0, ck:1, en:0, din:8'h00, done:0, rdy:1};

  exp_t q[$];
  exp_t cur = IDLE_E;
  int   wph = 0, wcnt = 0;
  logic e_wdone = 0, e_wfail = 0, e_wstage = 0;
  bit   saw_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int band_ref(input int rate);
    for (int i = 0; i < NB; i++) begin
      int mx;
      mx = (i == NB - 1) ? BT : BB + i * BS;
      if (mx >= rate) return i;
    end
    return -1;
  endfunction

  // reference model, updated on each edge, compared 2 ns later
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = IDLE_E;
      wph = 0; wcnt = 0; e_wdone = 0; e_wfail = 0; e_wstage = 0;
    end else begin
      if (cur.rdy && req_valid) begin
        if (req_clear) begin
          for (int i = 0; i < H; i++) q.push_back('{0, 1, 0, 8'h00, 0, 0});
          for (int i = 0; i < H; i++) q.push_back('{1, 1, 0, 8'h00, 0, 0});
        end else begin
          for (int i = 0; i < H; i++) q.push_back('{0, 1, 1, req_code, 0, 0});
          for (int i = 0; i < H; i++) q.push_back('{0, 0, 1, req_code, 0, 0});
          for (int i = 0; i < H; i++) q.push_back('{0, 0, 0, req_data, 0, 0});
          for (int i = 0; i < H; i++) q.push_back('{0, 1, 0, req_data, 0, 0});
        end
        q.push_back('{0, 1, 0, 8'h00, 1, 1});
      end
      cur = (q.size() > 0) ? q.pop_front() : IDLE_E;

      e_wdone = 0; e_wfail = 0;
      case (wph)
        0: if (wstart) begin wph = 1; wcnt = 0; end
        1: if (lock) begin wph = 2; wcnt = 0; end
           else if (wcnt == TO - 1) begin wph = 0; e_wdone = 1; e_wfail = 1; e_wstage = 0; end
           else wcnt++;
        default: if (stop) begin wph = 0; e_wdone = 1; end
           else if (wcnt == TO - 1) begin wph = 0; e_wdone = 1; e_wfail = 1; e_wstage = 1; end
           else wcnt++;
      endcase

      #2;
      chk(tclr == cur.clr, "R2 clear line", tclr, cur.clr);
      chk(ten == cur.en, "R3 enable", ten, cur.en);
      chk(tclk == cur.ck, "R4 test clock", tclk, cur.ck);
      chk(tdin == cur.din, "R5 data bus", tdin, cur.din);
      chk(req_done == cur.done, "R6 done", req_done, cur.done);
      chk(req_ready == cur.rdy, "R6 ready", req_ready, cur.rdy);
      chk(wbusy == (wph != 0), "R10 busy", wbusy, wph != 0);
      chk(wdone == e_wdone, "R10 wait done", wdone, e_wdone);
      chk(wfail == e_wfail, "R11 wait fail", wfail, e_wfail);
      chk(wstage == e_wstage, "R11 fail stage", wstage, e_wstage);
      if (wfail) saw_fail = 1;
    end
  end

  task automatic issue(input bit clr, input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_clear = clr; req_code = c; req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done_seen();
    do @(negedge clk); while (!req_done);
  endtask

  task automatic band_chk(input int rate);
    int r;
    band_rate = RW'(rate);
    #1;
    r = band_ref(rate);
    if (r < 0) chk(band_err == 1'b1, "R9 band error", band_err, 1);
    else begin
      chk(band_err == 1'b0, "R8 band error", band_err, 0);
      chk(int'(band_sel) == r, "R8 band select", band_sel, r);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset levels
    chk(tclk && !tclr && !ten && tdin == 0 && req_ready && !req_done, "R1 reset state",
        {tclk, tclr, ten, req_ready}, 4'b1001);

    issue(1, 8'h00, 8'h00);                 // R2 clear
    wait_done_seen();
    issue(0, 8'h5A, 8'hC3);                 // R3 R4 R5
    // R6: requests while busy are ignored
    req_valid = 1; req_code = 8'hEE; req_data = 8'h11;
    repeat (5) @(negedge clk);
    chk(!req_ready, "R6 busy ready", req_ready, 0);
    req_valid = 0;
    wait_done_seen();
    // R7: back-to-back in the done cycle
    req_valid = 1; req_clear = 0; req_code = 8'h81; req_data = 8'h7E;
    @(negedge clk);
    req_valid = 0;
    chk(ten && tdin == 8'h81, "R7 back-to-back start", tdin, 8'h81);
    wait_done_seen();
    req_valid = 1; req_code = 8'hFF; req_data = 8'h00;
    @(negedge clk);
    req_valid = 0;
    wait_done_seen();

    // R8 R9 band lookup
    band_chk(0); band_chk(89); band_chk(90); band_chk(129); band_chk(130);
    band_chk(1449); band_chk(1450); band_chk(1500);
    band_chk(1501); band_chk(4095);

    // R10 success path
    @(negedge clk); wstart = 1;
    @(negedge clk); wstart = 0;
    repeat (3) @(negedge clk); lock = 1;
    repeat (5) @(negedge clk); stop = 1;
    @(negedge clk); lock = 0; stop = 0;
    repeat (3) @(negedge clk);

    // R11 lock timeout
    saw_fail = 0;
    @(negedge clk); wstart = 1;
    @(negedge clk); wstart = 0;
    repeat (TO + 3) @(negedge clk);
    chk(saw_fail && !wstage, "R11 lock timeout", {saw_fail, wstage}, 2'b10);

    // R11 stop-state timeout
    saw_fail = 0;
    @(negedge clk); wstart = 1; lock = 1;
    @(negedge clk); wstart = 0;
    @(negedge clk); lock = 0;
    repeat (TO + 3) @(negedge clk);
    chk(saw_fail && wstage, "R11 stop timeout", {saw_fail, wstage}, 2'b11);

    // R12 lock on the last window cycle wins
    saw_fail = 0;
    @(negedge clk); wstart = 1;
    @(negedge clk); wstart = 0;
    repeat (TO - 1) @(negedge clk);
    lock = 1;
    @(negedge clk); lock = 0;
    #3;
    chk(wbusy && !saw_fail, "R12 late lock accepted", {wbusy, saw_fail}, 2'b10);
    stop = 1;
    @(negedge clk); stop = 0;
    repeat (3) @(negedge clk);
    chk(!saw_fail, "R12 no failure", saw_fail, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule